// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block predicts whether a conditional branch will be taken. Two component predictors run side by side. The per-branch side tracks how this particular branch has behaved: a history register, picked by low-order PC bits, indexes a table of 2-bit pattern counters. The path side tracks what all recent branches did: one shared outcome history indexes its own table of 2-bit counters. A third table of 2-bit selector counters, indexed by the shared history, chooses which of the two answers becomes the final prediction.

The lookup port is purely combinational. It takes a PC and returns the final direction, both component directions and which side was chosen. The training port is written on the clock edge. It takes the branch PC, the resolved outcome and the two component directions that the lookup reported for that branch, and it trains all three tables and both kinds of history. Table sizes are parameters. The defaults are small; the parameters can be raised to a 1K x 10-bit per-branch history with 4K path and selector entries.

Top module: `tournament_bp`

## Requirements
- R1: A synchronous active-high reset sets every pattern and path counter to 2'b01 (weakly not taken), sets every selector counter to 2'b10 (weakly favour the path side) and clears every history to zero. After reset, every lookup therefore reports not taken, with the path side selected.
- R2: The per-branch prediction is the MSB of the pattern counter indexed by the history register that PC bits [PC_LSB+LIDX_W-1:PC_LSB] select.
- R3: A valid training write shifts the outcome (1 = taken) into the LSB of the selected per-branch history register.
- R4: The path prediction is the MSB of the path counter indexed by the shared history. Every valid training write shifts the outcome into the LSB of the shared history.
- R5: Pattern and path counters are 2-bit saturating counters. They step up on taken and down on not taken, and they stop at 0 and at 3. Training uses the entry that the pre-write histories address.
- R6: A selector counter changes only on a valid write whose two reported component directions differ. It steps up (toward the path side) when the path direction matched the outcome and down otherwise, saturating at 0 and 3. It is indexed by the pre-write shared history.
- R7: A selector MSB of 1 selects the path side. Starting from a strongly held side, the selection moves to the other side only after two writes in which the favoured side was wrong and the other side was right.
- R8: The final prediction equals the direction of the side that the selector chooses. When both sides agree, it equals their common direction.
- R9: With upd_valid low, no table or history changes, so later lookups return the same results as before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pred_pc | input | PC_W | PC of the branch being looked up |
| pred_taken | output | 1 | Final direction |
| pred_local | output | 1 | Per-branch component direction |
| pred_global | output | 1 | Path component direction |
| pred_use_global | output | 1 | 1 when the path side was chosen |
| upd_valid | input | 1 | Training write enable |
| upd_pc | input | PC_W | PC of the resolved branch |
| upd_taken | input | 1 | Resolved outcome, 1 = taken |
| upd_local_pred | input | 1 | Per-branch direction reported at lookup |
| upd_global_pred | input | 1 | Path direction reported at lookup |

## Verification
Lookup results are combinational, so they are due in the same cycle the PC is driven. A training write takes effect at the next rising edge and is visible to the first lookup after it. The driver sets inputs just after a rising edge and queues the values its own model expects for that cycle. The monitor pops and compares them at the falling edge of the same cycle, before the write lands. Selector behaviour is steered directly by feeding chosen component directions on the training port, and idle cycles are bracketed by identical lookups to show that nothing moved.

// File: rtl/tp_pkg.sv
package tp_pkg;

    typedef logic [1:0] ctr2_t;

    localparam ctr2_t CTR_WEAK_NT   = 2'b01;
    localparam ctr2_t SEL_WEAK_PATH = 2'b10;

    typedef struct packed {
        logic valid;
        logic taken;
        logic lpred;
        logic gpred;
    } tp_upd_t;

    function automatic ctr2_t ctr_train(input ctr2_t c, input logic up);
        ctr2_t r;
        if (up) r = (c == 2'b11) ? c : c + 2'b01;
        else    r = (c == 2'b00) ? c : c - 2'b01;
        return r;
    endfunction

    function automatic logic ctr_dir(input ctr2_t c);
        return c[1];
    endfunction

endpackage

// File: rtl/tp_local.sv
module tp_local
    import tp_pkg::*;
#(
    parameter int PC_W   = 32,
    parameter int PC_LSB = 2,
    parameter int IDX_W  = 8,
    parameter int HIST_W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [PC_W-1:0] rd_pc,
    input  logic [PC_W-1:0] wr_pc,
    input  tp_upd_t         upd,
    output logic            rd_dir
);
    localparam int HENT = 1 << IDX_W;
    localparam int CENT = 1 << HIST_W;

    logic [HIST_W-1:0] hist_q [HENT];
    ctr2_t             pat_q  [CENT];

    logic [IDX_W-1:0]  rd_idx, wr_idx;
    logic [HIST_W-1:0] rd_hist, wr_hist;

    assign rd_idx  = rd_pc[PC_LSB +: IDX_W];
    assign wr_idx  = wr_pc[PC_LSB +: IDX_W];
    assign rd_hist = hist_q[rd_idx];
    assign wr_hist = hist_q[wr_idx];
    assign rd_dir  = ctr_dir(pat_q[rd_hist]);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < HENT; i++) hist_q[i] <= '0;
            for (int i = 0; i < CENT; i++) pat_q[i] <= CTR_WEAK_NT;
        end else if (upd.valid) begin
            pat_q[wr_hist] <= ctr_train(pat_q[wr_hist], upd.taken);
            hist_q[wr_idx] <= {wr_hist[HIST_W-2:0], upd.taken};
        end
    end
endmodule

// File: rtl/tp_global.sv
module tp_global
    import tp_pkg::*;
#(
    parameter int GHIST_W = 10
) (
    input  logic               clk,
    input  logic               rst,
    input  tp_upd_t            upd,
    output logic [GHIST_W-1:0] ghr,
    output logic               rd_dir
);
    localparam int GENT = 1 << GHIST_W;

    ctr2_t              ctr_q [GENT];
    logic [GHIST_W-1:0] ghr_q;

    assign ghr    = ghr_q;
    assign rd_dir = ctr_dir(ctr_q[ghr_q]);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < GENT; i++) ctr_q[i] <= CTR_WEAK_NT;
            ghr_q <= '0;
        end else if (upd.valid) begin
            ctr_q[ghr_q] <= ctr_train(ctr_q[ghr_q], upd.taken);
            ghr_q        <= {ghr_q[GHIST_W-2:0], upd.taken};
        end
    end
endmodule

// File: rtl/tp_chooser.sv
module tp_chooser
    import tp_pkg::*;
#(
    parameter int GHIST_W = 10
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [GHIST_W-1:0] ghr,
    input  tp_upd_t            upd,
    output logic               use_path,
    output logic               wr_en
);
    localparam int SENT = 1 << GHIST_W;

    ctr2_t sel_q [SENT];

    assign use_path = ctr_dir(sel_q[ghr]);
    assign wr_en    = upd.valid && (upd.lpred != upd.gpred);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < SENT; i++) sel_q[i] <= SEL_WEAK_PATH;
        end else if (wr_en) begin
            sel_q[ghr] <= ctr_train(sel_q[ghr], upd.gpred == upd.taken);
        end
    end
endmodule

// File: rtl/tournament_bp.sv
module tournament_bp
    import tp_pkg::*;
#(
    parameter int PC_W    = 32,
    parameter int PC_LSB  = 2,
    parameter int LIDX_W  = 8,
    parameter int LHIST_W = 8,
    parameter int GHIST_W = 10
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [PC_W-1:0] pred_pc,
    output logic            pred_taken,
    output logic            pred_local,
    output logic            pred_global,
    output logic            pred_use_global,
    input  logic            upd_valid,
    input  logic [PC_W-1:0] upd_pc,
    input  logic            upd_taken,
    input  logic            upd_local_pred,
    input  logic            upd_global_pred
);
    tp_upd_t            upd;
    logic [GHIST_W-1:0] ghr_w;
    logic               l_dir, g_dir, sel_w, ch_we_w;

    assign upd = '{valid: upd_valid, taken: upd_taken,
                   lpred: upd_local_pred, gpred: upd_global_pred};

    tp_local #(.PC_W(PC_W), .PC_LSB(PC_LSB), .IDX_W(LIDX_W), .HIST_W(LHIST_W)) u_local (
        .clk(clk), .rst(rst), .rd_pc(pred_pc), .wr_pc(upd_pc), .upd(upd), .rd_dir(l_dir)
    );

    tp_global #(.GHIST_W(GHIST_W)) u_global (
        .clk(clk), .rst(rst), .upd(upd), .ghr(ghr_w), .rd_dir(g_dir)
    );

    tp_chooser #(.GHIST_W(GHIST_W)) u_chooser (
        .clk(clk), .rst(rst), .ghr(ghr_w), .upd(upd), .use_path(sel_w), .wr_en(ch_we_w)
    );

    assign pred_local      = l_dir;
    assign pred_global     = g_dir;
    assign pred_use_global = sel_w;
    assign pred_taken      = sel_w ? g_dir : l_dir;
endmodule

// File: rtl/tournament_bp_chk.sv
module tournament_bp_chk #(
    parameter int GHIST_W = 10
) (
    input logic               clk,
    input logic               rst,
    input logic               upd_valid,
    input logic               upd_taken,
    input logic               upd_local_pred,
    input logic               upd_global_pred,
    input logic [GHIST_W-1:0] ghr,
    input logic               ch_we,
    input logic               pred_local,
    input logic               pred_global,
    input logic               pred_taken
);
    a_r1_history_cleared: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> ghr == '0);

    a_r4_history_shift: assert property (@(posedge clk) disable iff (rst)
        upd_valid |=> ghr == {$past(ghr[GHIST_W-2:0]), $past(upd_taken)});

    a_r9_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !upd_valid |=> $stable(ghr));

    a_r6_selector_gate: assert property (@(posedge clk) disable iff (rst)
        ch_we |-> (upd_valid && (upd_local_pred != upd_global_pred)));

    a_r8_agree_passes: assert property (@(posedge clk) disable iff (rst)
        (pred_local == pred_global) |-> (pred_taken == pred_local));
endmodule

bind tournament_bp tournament_bp_chk #(.GHIST_W(GHIST_W)) u_chk (
    .clk(clk), .rst(rst), .upd_valid(upd_valid), .upd_taken(upd_taken),
    .upd_local_pred(upd_local_pred), .upd_global_pred(upd_global_pred),
    .ghr(ghr_w), .ch_we(ch_we_w), .pred_local(pred_local),
    .pred_global(pred_global), .pred_taken(pred_taken)
);

// File: tb/tournament_bp_bench.sv
module tournament_bp_bench;
    localparam int PC_W = 32, PC_LSB = 2, LIDX_W = 8, LHIST_W = 8, GHIST_W = 10;

    logic clk = 0, rst = 1;
    logic [PC_W-1:0] pred_pc = '0, upd_pc = '0;
    logic upd_valid = 0, upd_taken = 0, upd_local_pred = 0, upd_global_pred = 0;
    logic pred_taken, pred_local, pred_global, pred_use_global;

    always #4 clk = ~clk;

    tournament_bp u_tournament_bp (
        .clk(clk), .rst(rst), .pred_pc(pred_pc), .pred_taken(pred_taken),
        .pred_local(pred_local), .pred_global(pred_global),
        .pred_use_global(pred_use_global), .upd_valid(upd_valid), .upd_pc(upd_pc),
        .upd_taken(upd_taken), .upd_local_pred(upd_local_pred),
        .upd_global_pred(upd_global_pred)
    );

    typedef struct { bit l; bit g; bit sel; bit fin; string req; } exp_t;
    exp_t q[$];
    int checks = 0, fails = 0;
    bit done = 0;

    logic [LHIST_W-1:0] m_lh  [1 << LIDX_W];
    logic [1:0]         m_lc  [1 << LHIST_W];
    logic [1:0]         m_gc  [1 << GHIST_W];
    logic [1:0]         m_sel [1 << GHIST_W];
    logic [GHIST_W-1:0] m_ghr;

    function automatic logic [1:0] sat(input logic [1:0] c, input logic up);
        if (up) return (c == 2'd3) ? c : c + 2'd1;
        return (c == 2'd0) ? c : c - 2'd1;
    endfunction

    task automatic model_reset();
        foreach (m_lh[i])  m_lh[i]  = '0;
        foreach (m_lc[i])  m_lc[i]  = 2'b01;
        foreach (m_gc[i])  m_gc[i]  = 2'b01;
        foreach (m_sel[i]) m_sel[i] = 2'b10;
        m_ghr = '0;
    endtask

    task automatic step(input logic [PC_W-1:0] pc, input bit valid, input bit t,
                        input bit force_c, input bit fl, input bit fg, input string req);
        logic [LIDX_W-1:0] li;
        logic [LHIST_W-1:0] lh;
        exp_t e;
        bit lp, gp;
        li = pc[PC_LSB +: LIDX_W];
        lh = m_lh[li];
        e.l = m_lc[lh][1];
        e.g = m_gc[m_ghr][1];
        e.sel = m_sel[m_ghr][1];
        e.fin = e.sel ? e.g : e.l;
        e.req = req;
        @(posedge clk); #1;
        pred_pc = pc;
        q.push_back(e);
        lp = force_c ? fl : e.l;
        gp = force_c ? fg : e.g;
        upd_valid = valid; upd_pc = pc; upd_taken = t;
        upd_local_pred = lp; upd_global_pred = gp;
        if (valid) begin
            m_lc[lh] = sat(m_lc[lh], t);
            m_lh[li] = {lh[LHIST_W-2:0], t};
            m_gc[m_ghr] = sat(m_gc[m_ghr], t);
            if (lp != gp) m_sel[m_ghr] = sat(m_sel[m_ghr], gp == t);
            m_ghr = {m_ghr[GHIST_W-2:0], t};
        end
    endtask

    task automatic cmp(input bit a, input bit x, input string what, input string req);
        checks++;
        if (a !== x) begin
            fails++;
            $display("FAIL %s %s: actual %0b expected %0b", req, what, a, x);
        end
    endtask

    always @(negedge clk) begin
        exp_t e;
        if (q.size() > 0) begin
            e = q.pop_front();
            cmp(pred_local, e.l, "local dir (R2)", e.req);
            cmp(pred_global, e.g, "path dir (R4)", e.req);
            cmp(pred_use_global, e.sel, "selector (R6)", e.req);
            cmp(pred_taken, e.fin, "final dir (R8)", e.req);
        end
    end

    initial begin
        logic [31:0] lf;
        model_reset();
        repeat (3) @(posedge clk);
        #1 rst = 0;
        step(32'h0, 0, 0, 0, 0, 0, "R1");
        step(32'h40, 0, 0, 0, 0, 0, "R1");
        // selector steering at shared history 0 (not-taken outcomes keep it 0)
        step(32'h100, 1, 0, 1, 0, 1, "R6");   // path wrong: 10 -> 01
        step(32'h100, 0, 0, 0, 0, 0, "R7");   // now per-branch side chosen
        step(32'h100, 1, 0, 1, 1, 1, "R6");   // agree: no change
        step(32'h100, 0, 0, 0, 0, 0, "R6");
        step(32'h100, 1, 0, 1, 1, 0, "R7");   // 01 -> 10
        step(32'h100, 1, 0, 1, 1, 0, "R7");   // 10 -> 11
        step(32'h100, 1, 0, 1, 0, 1, "R7");   // 11 -> 10, still path
        step(32'h100, 0, 0, 0, 0, 0, "R7");
        step(32'h100, 1, 0, 1, 0, 1, "R7");   // 10 -> 01, switch
        step(32'h100, 0, 0, 0, 0, 0, "R7");
        // saturation on an always-taken branch
        for (int i = 0; i < 20; i++) step(32'h204, 1, 1, 0, 0, 0, "R5");
        // alternating pattern trains per-branch history
        for (int i = 0; i < 40; i++) step(32'h308, 1, i[0], 0, 0, 0, "R3");
        // idle cycles bracketed by identical lookups
        step(32'h308, 0, 0, 0, 0, 0, "R9");
        for (int i = 0; i < 3; i++) step(32'h308, 0, 1, 1, 1, 0, "R9");
        step(32'h308, 0, 0, 0, 0, 0, "R9");
        lf = 32'hACE1_2345;
        for (int i = 0; i < 1500; i++) begin
            lf ^= lf << 13; lf ^= lf >> 17; lf ^= lf << 5;
            step({24'h0, lf[5:0], 2'b00}, 1, lf[9] | lf[10], 0, 0, 0, "R2 R4 R5 R8");
        end
        step(32'h0, 0, 0, 0, 0, 0, "R9");
        @(posedge clk); #1 upd_valid = 0;
        repeat (2) @(posedge clk);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule